// File: doc/BRIEF.md
# Contiguous Slot Allocator for a Region-Partitioned Scratch Memory

This block hands out runs of adjacent slots in a small local scratch memory that is cut into equal regions. A requester may own one region privately. Every region flagged as shareable forms a common pool that any requester can draw from. A requester raises its request line with a run length. The block answers in the same cycle with a grant pulse and the first slot of the run. It always tries the requester's own region first and falls back to the shared pool. If neither holds a long enough free run, the requester is parked. It is tried again only after some slot of the shared pool has been released.

A separate release port returns a run of slots. The block decides from the start slot whether the run lies in the named requester's private region or in the shared pool, and clears the matching bitmap. Region ownership and the shareable set are static inputs. They are loaded from outside, and the shared bitmap is seeded from the shareable set while reset is held. Software typically claims two 2-slot runs per requester right after start-up, one for key data and one for context, and then allocates and frees short runs as work proceeds.

Top module: `slot_alloc`

## Requirements
- R1: While reset is held, all private bitmaps are cleared, no requester is parked, and every slot of a region whose bit in `shared_regions_i` is 0 is marked busy in the shared bitmap. The shared set is sampled from the input during reset. With no request pending, `grant_o` is 0.
- R2: A requester with `priv_en_i[r]`=1 is first served from its own region `priv_region_i[3r+2:3r]`. The returned slot is region*16 + offset, where offset is the lowest free run inside that region.
- R3: The search is first-fit. The granted start is the lowest index at which `count` adjacent free slots begin, for counts 1 to 4 carried in the 3-bit field `req_count_i[3r+2:3r]`. A private run never crosses its region's end.
- R4: When the private region has no fit, the shared bitmap over all 128 slots is searched in the same way. A run starting in a non-shareable region is never granted.
- R5: A requester with `priv_en_i[r]`=0 goes straight to the shared search.
- R6: At most one requester is granted per cycle. It is the lowest-index requester that has `req_valid_i` high and is not parked.
- R7: The grant is combinational, in the same cycle as the request. The allocated slots are busy from the next clock edge, so the requester drops its request after the edge on which it was granted.
- R8: A selected request that fits nowhere parks its requester, and a parked requester is not considered again until a shared release occurs. A release into a private region does not wake it. A parked requester does not block lower-priority requesters.
- R9: A release whose start slot lies in the private region of `free_id_i` clears `free_count_i` bits of that private bitmap. Any other release clears bits of the shared bitmap.
- R10: A release and a search in the same cycle see the bitmaps as they were before the release. A shared release in the same cycle as a failed search still leaves the requester unparked, so it is retried in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_en_i | input | 4 | Per requester: owns a private region |
| priv_region_i | input | 12 | Per requester: 3-bit private region index |
| shared_regions_i | input | 8 | Per region: 1 if the region belongs to the shared pool |
| req_valid_i | input | 4 | Per requester: request pending |
| req_count_i | input | 12 | Per requester: 3-bit run length, 1 to 4 |
| grant_o | output | 4 | One-hot grant, same cycle as the request |
| grant_slot_o | output | 7 | First slot of the granted run |
| free_valid_i | input | 1 | Release strobe |
| free_id_i | input | 2 | Requester that owned the run |
| free_start_i | input | 7 | First slot of the released run |
| free_count_i | input | 3 | Length of the released run |

## Verification
The release path and the search path can act in the same cycle. In that cycle the search must use the bitmaps as they stood before the release, while the shared release must override the parking of a requester whose search just failed. The bench provokes this by raising a request that cannot fit while releasing, in the same cycle, the one shared run that would make it fit. It judges the result by seeing no grant in that cycle and a grant at exactly the released start in the next one. A second case releases into a parked requester's private region and confirms that the requester stays silent.

// File: rtl/slot_alloc_pkg.sv
`timescale 1ns/1ps
package slot_alloc_pkg;
  localparam int SA_NUM_REQ      = 4;
  localparam int SA_NUM_REGIONS  = 8;
  localparam int SA_REGION_SLOTS = 16;
  localparam int SA_MAX_RUN      = 4;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_PRIV   = 2'd1,
    SRC_SHARED = 2'd2,
    SRC_STALL  = 2'd3
  } grant_src_e;
endpackage

// File: rtl/slot_run_finder.sv
`timescale 1ns/1ps
module slot_run_finder #(
  parameter int WIDTH   = 16,
  parameter int MAX_RUN = 4,
  parameter int CNT_W   = 3,
  parameter int IDX_W   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] busy_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             fit_o,
  output logic [IDX_W-1:0] start_o
);
  logic [WIDTH-1:0] fits;
  logic             count_ok;

  assign count_ok = (count_i != '0) && (count_i <= CNT_W'(MAX_RUN));

  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    logic [MAX_RUN-1:0] hit;
    for (genvar k = 0; k < MAX_RUN; k++) begin : g_k
      if (i + k < WIDTH) begin : g_in
        assign hit[k] = (count_i > CNT_W'(k)) & busy_i[i+k];
      end else begin : g_out
        assign hit[k] = (count_i > CNT_W'(k));
      end
    end
    assign fits[i] = count_ok & ~(|hit);
  end

  always_comb begin
    fit_o   = |fits;
    start_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (fits[i]) start_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/slot_req_arbiter.sv
`timescale 1ns/1ps
module slot_req_arbiter #(
  parameter int N    = 4,
  parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    eligible_i,
  output logic [N-1:0]    onehot_o,
  output logic [ID_W-1:0] idx_o,
  output logic            any_o
);
  always_comb begin
    onehot_o = '0;
    idx_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eligible_i[i]) begin
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
        idx_o       = ID_W'(i);
      end
    end
    any_o = |eligible_i;
  end
endmodule

// File: rtl/slot_alloc.sv
`timescale 1ns/1ps
module slot_alloc
  import slot_alloc_pkg::*;
#(
  parameter int NUM_REQ      = SA_NUM_REQ,
  parameter int NUM_REGIONS  = SA_NUM_REGIONS,
  parameter int REGION_SLOTS = SA_REGION_SLOTS,
  parameter int MAX_RUN      = SA_MAX_RUN,
  parameter int ID_W         = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  parameter int REG_W        = $clog2(NUM_REGIONS),
  parameter int OFF_W        = $clog2(REGION_SLOTS),
  parameter int SLOT_W       = REG_W + OFF_W,
  parameter int CNT_W        = $clog2(MAX_RUN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       priv_en_i,
  input  logic [NUM_REQ*REG_W-1:0] priv_region_i,
  input  logic [NUM_REGIONS-1:0]   shared_regions_i,
  input  logic [NUM_REQ-1:0]       req_valid_i,
  input  logic [NUM_REQ*CNT_W-1:0] req_count_i,
  output logic [NUM_REQ-1:0]       grant_o,
  output logic [SLOT_W-1:0]        grant_slot_o,
  input  logic                     free_valid_i,
  input  logic [ID_W-1:0]          free_id_i,
  input  logic [SLOT_W-1:0]        free_start_i,
  input  logic [CNT_W-1:0]         free_count_i
);
  localparam int TOTAL_SLOTS = NUM_REGIONS * REGION_SLOTS;

  // Mask of cnt adjacent bits from start, over the whole memory.
  function automatic logic [TOTAL_SLOTS-1:0] run_bits_all(
    input logic [SLOT_W-1:0] start, input logic [CNT_W-1:0] cnt);
    logic [TOTAL_SLOTS-1:0] m;
    m = '0;
    for (int k = 0; k < MAX_RUN; k++) begin
      if ((k < int'(cnt)) && (int'(start) + k < TOTAL_SLOTS))
        m[int'(start) + k] = 1'b1;
    end
    return m;
  endfunction

  // Same mask, limited to one region.
  function automatic logic [REGION_SLOTS-1:0] run_bits_region(
    input logic [OFF_W-1:0] off, input logic [CNT_W-1:0] cnt);
    logic [REGION_SLOTS-1:0] m;
    m = '0;
    for (int k = 0; k < MAX_RUN; k++) begin
      if ((k < int'(cnt)) && (int'(off) + k < REGION_SLOTS))
        m[int'(off) + k] = 1'b1;
    end
    return m;
  endfunction

  // State
  logic [TOTAL_SLOTS-1:0]                shared_map_q, shared_map_d, shared_init;
  logic [NUM_REQ-1:0][REGION_SLOTS-1:0]  priv_map_q, priv_map_d;
  logic [NUM_REQ-1:0]                    waiting_q, waiting_d;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_init
    assign shared_init[g*REGION_SLOTS +: REGION_SLOTS] = {REGION_SLOTS{~shared_regions_i[g]}};
  end

  // Arbitration
  logic [NUM_REQ-1:0] eligible, sel_oh;
  logic [ID_W-1:0]    sel_idx;
  logic               sel_any;

  assign eligible = req_valid_i & ~waiting_q;

  slot_req_arbiter #(.N(NUM_REQ), .ID_W(ID_W)) u_arb (
    .eligible_i(eligible),
    .onehot_o  (sel_oh),
    .idx_o     (sel_idx),
    .any_o     (sel_any)
  );

  logic [CNT_W-1:0]        sel_count;
  logic [REG_W-1:0]        sel_region;
  logic                    sel_priv_en;
  logic [REGION_SLOTS-1:0] sel_pmap;

  assign sel_count   = req_count_i[sel_idx*CNT_W +: CNT_W];
  assign sel_region  = priv_region_i[sel_idx*REG_W +: REG_W];
  assign sel_priv_en = priv_en_i[sel_idx];
  assign sel_pmap    = priv_map_q[sel_idx];

  // Two-tier search
  logic              pfit, sfit;
  logic [OFF_W-1:0]  poff;
  logic [SLOT_W-1:0] sstart;

  slot_run_finder #(.WIDTH(REGION_SLOTS), .MAX_RUN(MAX_RUN), .CNT_W(CNT_W), .IDX_W(OFF_W)) u_priv_find (
    .busy_i (sel_pmap),
    .count_i(sel_count),
    .fit_o  (pfit),
    .start_o(poff)
  );

  slot_run_finder #(.WIDTH(TOTAL_SLOTS), .MAX_RUN(MAX_RUN), .CNT_W(CNT_W), .IDX_W(SLOT_W)) u_shared_find (
    .busy_i (shared_map_q),
    .count_i(sel_count),
    .fit_o  (sfit),
    .start_o(sstart)
  );

  grant_src_e grant_src;
  always_comb begin
    if (!sel_any)                 grant_src = SRC_NONE;
    else if (sel_priv_en && pfit) grant_src = SRC_PRIV;
    else if (sfit)                grant_src = SRC_SHARED;
    else                          grant_src = SRC_STALL;
  end

  // Named events
  logic ev_grant_priv, ev_grant_shared, ev_fail;
  assign ev_grant_priv   = (grant_src == SRC_PRIV);
  assign ev_grant_shared = (grant_src == SRC_SHARED);
  assign ev_fail         = (grant_src == SRC_STALL);

  assign grant_o      = (ev_grant_priv || ev_grant_shared) ? sel_oh : '0;
  assign grant_slot_o = ev_grant_priv   ? {sel_region, poff} :
                        ev_grant_shared ? sstart : '0;

  // Release classification
  logic [REG_W-1:0] free_region, free_owner_region;
  logic             free_in_priv, ev_priv_free, ev_shared_free;

  assign free_region       = free_start_i[SLOT_W-1 -: REG_W];
  assign free_owner_region = priv_region_i[free_id_i*REG_W +: REG_W];
  assign free_in_priv      = priv_en_i[free_id_i] && (free_owner_region == free_region);
  assign ev_priv_free      = free_valid_i &&  free_in_priv;
  assign ev_shared_free    = free_valid_i && !free_in_priv;

  // Next-state masks
  logic [TOTAL_SLOTS-1:0]  sh_clr, sh_set;
  logic [REGION_SLOTS-1:0] pv_clr, pv_set;

  assign sh_clr = ev_shared_free  ? run_bits_all(free_start_i, free_count_i) : '0;
  assign sh_set = ev_grant_shared ? run_bits_all(sstart, sel_count) : '0;
  assign pv_clr = run_bits_region(free_start_i[OFF_W-1:0], free_count_i);
  assign pv_set = run_bits_region(poff, sel_count);

  always_comb begin
    shared_map_d = (shared_map_q & ~sh_clr) | sh_set;
    for (int r = 0; r < NUM_REQ; r++) begin
      priv_map_d[r] = priv_map_q[r];
      if (ev_priv_free && (free_id_i == ID_W'(r)))
        priv_map_d[r] = priv_map_d[r] & ~pv_clr;
      if (ev_grant_priv && (sel_idx == ID_W'(r)))
        priv_map_d[r] = priv_map_d[r] | pv_set;
    end
    if (ev_shared_free)
      waiting_d = '0;
    else
      waiting_d = (waiting_q | (ev_fail ? sel_oh : '0)) & req_valid_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shared_map_q <= shared_init;
      priv_map_q   <= '0;
      waiting_q    <= '0;
    end else begin
      shared_map_q <= shared_map_d;
      priv_map_q   <= priv_map_d;
      waiting_q    <= waiting_d;
    end
  end
endmodule

// File: rtl/slot_alloc_chk.sv
`timescale 1ns/1ps
module slot_alloc_chk #(
  parameter int NUM_REQ     = 4,
  parameter int NUM_REGIONS = 8,
  parameter int REG_W       = 3,
  parameter int SLOT_W      = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_REQ-1:0]     req_valid_i,
  input logic [NUM_REQ-1:0]     grant_o,
  input logic [SLOT_W-1:0]      grant_slot_o,
  input logic [NUM_REQ-1:0]     waiting_q,
  input logic                   ev_grant_priv,
  input logic                   ev_grant_shared,
  input logic                   ev_fail,
  input logic                   ev_shared_free,
  input logic [REG_W-1:0]       sel_region,
  input logic [NUM_REGIONS-1:0] shared_regions_i
);
  // R6: never more than one grant
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R7: a grant only goes to a requester that is asking
  p_grant_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_valid_i) == '0);

  // R6: no unparked lower-index requester is passed over
  p_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) |-> (((req_valid_i & ~waiting_q) & (grant_o - 1'b1)) == '0));

  // R2: a private grant lies in the owner's region
  p_priv_in_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant_priv |-> (grant_slot_o[SLOT_W-1 -: REG_W] == sel_region));

  // R4: a shared grant starts inside a shareable region
  p_shared_in_pool_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant_shared |-> shared_regions_i[grant_slot_o[SLOT_W-1 -: REG_W]]);

  // R8: a failed search produces no grant
  p_fail_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |-> (grant_o == '0));

  // R8: a parked requester stays silent until a shared release
  p_park_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & $past(waiting_q) & $past(req_valid_i) &
     ~{NUM_REQ{$past(ev_shared_free)}}) == '0);

  // R10: a shared release leaves nobody parked
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shared_free |=> (waiting_q == '0));
endmodule

bind slot_alloc slot_alloc_chk #(
  .NUM_REQ    (NUM_REQ),
  .NUM_REGIONS(NUM_REGIONS),
  .REG_W      (REG_W),
  .SLOT_W     (SLOT_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid_i     (req_valid_i),
  .grant_o         (grant_o),
  .grant_slot_o    (grant_slot_o),
  .waiting_q       (waiting_q),
  .ev_grant_priv   (ev_grant_priv),
  .ev_grant_shared (ev_grant_shared),
  .ev_fail         (ev_fail),
  .ev_shared_free  (ev_shared_free),
  .sel_region      (sel_region),
  .shared_regions_i(shared_regions_i)
);

// File: tb/slot_alloc_test.sv
`timescale 1ns/1ps
module slot_alloc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  priv_en;
  logic [11:0] priv_region;
  logic [7:0]  shared_regions;
  logic [3:0]  req_valid;
  logic [11:0] req_count;
  logic [3:0]  grant;
  logic [6:0]  grant_slot;
  logic        free_valid;
  logic [1:0]  free_id;
  logic [6:0]  free_start;
  logic [2:0]  free_count;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  slot_alloc uut (
    .clk(clk), .rst_n(rst_n),
    .priv_en_i(priv_en), .priv_region_i(priv_region),
    .shared_regions_i(shared_regions),
    .req_valid_i(req_valid), .req_count_i(req_count),
    .grant_o(grant), .grant_slot_o(grant_slot),
    .free_valid_i(free_valid), .free_id_i(free_id),
    .free_start_i(free_start), .free_count_i(free_count)
  );

  typedef struct packed {
    logic [1:0] id;
    logic [2:0] cnt;
    logic [6:0] slot;
  } vec_t;

  // Config: r0 owns region 2, r1 region 5, r2 none, r3 region 7; only region 0 shared.
  localparam vec_t VEC [16] = '{
    '{2'd0, 3'd2, 7'd32},  // R2 start-up key run
    '{2'd0, 3'd2, 7'd34},  // R2 start-up context run, R7 map updated
    '{2'd1, 3'd2, 7'd80},
    '{2'd1, 3'd2, 7'd82},
    '{2'd2, 3'd2, 7'd0},   // R5 no private region, R4 regions 1.. skipped
    '{2'd2, 3'd2, 7'd2},
    '{2'd3, 3'd2, 7'd112},
    '{2'd3, 3'd2, 7'd114},
    '{2'd0, 3'd3, 7'd36},  // R3
    '{2'd0, 3'd1, 7'd39},
    '{2'd2, 3'd4, 7'd4},
    '{2'd0, 3'd4, 7'd40},
    '{2'd0, 3'd4, 7'd44},  // private region of r0 now full
    '{2'd0, 3'd1, 7'd8},   // R4 fallback to shared
    '{2'd2, 3'd4, 7'd9},
    '{2'd3, 3'd3, 7'd116}
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic req_one(input int id, input int cnt, input int slot, input string tag);
    @(negedge clk);
    req_valid[id] = 1'b1;
    req_count[id*3 +: 3] = 3'(cnt);
    #1;
    chk({tag, " grant"}, int'(grant), 1 << id);
    chk({tag, " slot"}, int'(grant_slot), slot);
    @(negedge clk);
    req_valid[id] = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] sh);
    @(negedge clk);
    rst_n = 1'b0;
    shared_regions = sh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R8 watchdog actual=5000 expected<5000 cycles");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    priv_en = 4'b1011;
    priv_region = {3'd7, 3'd0, 3'd5, 3'd2};
    shared_regions = 8'b0000_0001;
    req_valid = '0;
    req_count = '0;
    free_valid = 1'b0;
    free_id = '0;
    free_start = '0;
    free_count = '0;
    do_reset(8'b0000_0001);
    #1 chk("R1 idle grant", int'(grant), 0);

    for (int i = 0; i < 16; i++)
      req_one(int'(VEC[i].id), int'(VEC[i].cnt), int'(VEC[i].slot),
              $sformatf("R2/R3/R4/R5/R7 table %0d", i));

    // R8: r0 needs 4, only slots 13..15 free anywhere it may use
    @(negedge clk);
    req_valid[0] = 1'b1;
    req_count[2:0] = 3'd4;
    #1 chk("R8 no fit", int'(grant), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1 chk("R8 stalled", int'(grant), 0);
    end

    // R8: parked r0 does not block r2
    @(negedge clk);
    req_valid[2] = 1'b1;
    req_count[8:6] = 3'd2;
    #1 chk("R8 lower prio grant", int'(grant), 4);
    chk("R8 lower prio slot", int'(grant_slot), 13);
    @(negedge clk);
    req_valid[2] = 1'b0;
    #1 chk("R8 still parked", int'(grant), 0);

    // R8/R9: private release does not wake r0
    @(negedge clk);
    free_valid = 1'b1; free_id = 2'd0; free_start = 7'd32; free_count = 3'd2;
    #1 chk("R8 priv free cycle", int'(grant), 0);
    @(negedge clk);
    free_valid = 1'b0;
    for (int i = 0; i < 2; i++) begin
      #1 chk("R8 priv free no wake", int'(grant), 0);
      @(negedge clk);
    end

    // R9/R10: shared release wakes r0 next cycle
    free_valid = 1'b1; free_id = 2'd2; free_start = 7'd4; free_count = 3'd4;
    #1 chk("R10 no grant in release cycle", int'(grant), 0);
    @(negedge clk);
    free_valid = 1'b0;
    #1 chk("R9 wake grant", int'(grant), 1);
    chk("R9 wake slot", int'(grant_slot), 4);
    @(negedge clk);
    req_valid[0] = 1'b0;

    // R9: private release took effect
    req_one(0, 2, 32, "R9 private reuse");

    // R10: failing search and shared release in same cycle
    @(negedge clk);
    req_valid[2] = 1'b1;
    req_count[8:6] = 3'd2;
    free_valid = 1'b1; free_id = 2'd2; free_start = 7'd9; free_count = 3'd4;
    #1 chk("R10 pre-release view", int'(grant), 0);
    @(negedge clk);
    free_valid = 1'b0;
    #1 chk("R10 retry grant", int'(grant), 4);
    chk("R10 retry slot", int'(grant_slot), 9);
    @(negedge clk);
    req_valid[2] = 1'b0;

    // R6: simultaneous requests
    @(negedge clk);
    req_valid[1] = 1'b1; req_count[5:3] = 3'd1;
    req_valid[3] = 1'b1; req_count[11:9] = 3'd1;
    #1 chk("R6 priority grant", int'(grant), 2);
    chk("R6 priority slot", int'(grant_slot), 84);
    @(negedge clk);
    req_valid[1] = 1'b0;
    #1 chk("R6 next grant", int'(grant), 8);
    chk("R6 next slot", int'(grant_slot), 119);
    @(negedge clk);
    req_valid[3] = 1'b0;

    // R1: re-reset with region 1 as the shared pool
    do_reset(8'b0000_0010);
    #1 chk("R1 idle after reset", int'(grant), 0);
    req_one(2, 1, 16, "R1 shared seed");
    req_one(0, 1, 32, "R1 private cleared");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule